// File: doc/BRIEF.md
# SDRAM Bank Command Guard

This block watches the command pins of a four-bank synchronous DRAM and keeps a private model of every bank. Each bank is idle, opening a row, open, in a read or write burst that closes itself, in write recovery, or precharging. For every command on the pins, the guard judges it against the state of the bank or banks it touches. A command that the target bank cannot take in its present state raises a one-cycle flag. The flag comes with the bank that refused the command and a code for the command.

It sits next to a memory controller or on a bus probe and takes no part in traffic. Programmed row-open delay, precharge delay and burst length come in as plain configuration pins. A legal command moves the model on. A refused command is reported and leaves every bank as it was. Commands that act on all banks (precharge-all, refresh, mode set) are judged across all four banks, and the lowest refusing bank is reported.

The guard has no data stream, so there is no valid/ready handshake. A command is sampled on every rising clock edge, and the guard never applies back-pressure.

Top module: `sdram_cmd_guard`

## Requirements
- R1: While reset is held and on the first cycle after it, every bank reads idle (state code 0) and `illegal` is low with `illegal_bank` and `illegal_code` zero.
- R2: With `cs_n` high (deselect) the other command pins are ignored. Deselect and NOP (`cs_n,ras_n,cas_n,we_n` = 0111) are never flagged and change no bank. Command codes: NOP 0, burst stop 1 (0110), read 2 (0101), write 3 (0100), activate 4 (0011), precharge 5 (0010), refresh 6 (0001), mode set 7 (0000).
- R3: An activate to an idle bank puts it in opening (code 1) for `trcd_cfg` cycles, with 0 treated as 1. It then reads open (code 2).
- R4: While a bank is opening, a read, write, activate or precharge that touches it is flagged. NOP and burst stop are accepted.
- R5: A precharge with `a10`=0 to an open bank starts precharging (code 6) for `trp_cfg` cycles, with 0 treated as 1, and the bank then reads idle. A precharge to an idle or precharging bank is accepted and changes nothing.
- R6: A read or write to a bank that is not open is flagged, and so is an activate to a bank that is not idle.
- R7: A read with `a10`=1 to an open bank starts a self-closing read burst (code 3) that lasts the burst length in cycles, then precharges for `trp_cfg` cycles. While the burst runs, any read, write, activate or precharge to that bank is flagged. Commands to other banks are judged only by their own state.
- R8: A write with `a10`=1 to an open bank starts a self-closing write burst (code 4) for the burst length. It then spends 2 cycles in write recovery (code 5), then precharges. A burst stop addressed to a bank in a self-closing write burst is flagged. A read or write with `a10`=0 leaves an open bank open.
- R9: A precharge with `a10`=1 is judged against all four banks. It is flagged, with the lowest refusing bank reported, if any bank is opening, bursting or recovering. Otherwise every open bank starts precharging.
- R10: Refresh and mode set are accepted only when all four banks are idle. Otherwise they are flagged with the lowest non-idle bank reported.
- R11: A flagged command raises `illegal` for exactly the cycle after the edge that sampled it, with its bank and code beside it. A flagged command changes no bank state.
- R12: `bl_sel` values 0, 1, 2 and 3 give burst lengths of 1, 2, 4 and 8 cycles, taken when a self-closing burst begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples commands |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin |
| cas_n | input | 1 | Column strobe pin |
| we_n | input | 1 | Write enable pin |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select |
| trp_cfg | input | 4 | Precharge delay in cycles |
| trcd_cfg | input | 4 | Row-open delay in cycles |
| bl_sel | input | 2 | Burst length select |
| bank_state | output | 12 | Bank b state code at bits 3b+2:3b |
| illegal | output | 1 | One-cycle flag for a refused command |
| illegal_bank | output | 2 | Bank that refused the command |
| illegal_code | output | 3 | Code of the refused command |

## Verification
Each bank's state is visible on `bank_state` one cycle after the command or timer expiry that moves it. A bank model that has drifted therefore shows on the next cycle, before any command reaches it. A wrong timer shows as a transition one or more cycles early or late. Errors that stay in the legality logic show only when a later command is judged, as a missing or spurious `illegal` pulse or a wrong bank in `illegal_bank`. For this reason the bench compares every bank and the flag on every cycle against its own model.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [2:0] {
    C_NOP = 3'd0,
    C_BST = 3'd1,
    C_RD  = 3'd2,
    C_WR  = 3'd3,
    C_ACT = 3'd4,
    C_PRE = 3'd5,
    C_REF = 3'd6,
    C_MRS = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    B_IDLE    = 3'd0,
    B_OPENING = 3'd1,
    B_OPEN    = 3'd2,
    B_RD_AP   = 3'd3,
    B_WR_AP   = 3'd4,
    B_WR_REC  = 3'd5,
    B_CLOSING = 3'd6
  } bank_e;

  // Whether one bank in state st may take command c.
  function automatic logic bank_accepts(bank_e st, cmd_e c);
    case (c)
      C_NOP:        return 1'b1;
      C_BST:        return st != B_WR_AP;
      C_RD, C_WR:   return st == B_OPEN;
      C_ACT:        return st == B_IDLE;
      C_PRE:        return (st == B_IDLE) || (st == B_OPEN) || (st == B_CLOSING);
      default:      return st == B_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_guard_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = C_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = C_NOP;
        3'b110:  cmd = C_BST;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b011:  cmd = C_ACT;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = C_REF;
        default: cmd = C_MRS;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cmd_judge.sv
module sdram_cmd_judge
  import sdram_guard_pkg::*;
#(
  parameter int NBANK = 4,
  localparam int BA_W = $clog2(NBANK)
)(
  input  cmd_e            cmd,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  input  bank_e           st [NBANK],
  output logic            bad,
  output logic [BA_W-1:0] bad_bank,
  output logic [NBANK-1:0] hit
);
  logic             all_scope;
  logic [NBANK-1:0] covers;
  logic [NBANK-1:0] fail;

  assign all_scope = ((cmd == C_PRE) && a10) || (cmd == C_REF) || (cmd == C_MRS);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign covers[g] = all_scope || (ba == BA_W'(g));
    assign fail[g]   = covers[g] && !bank_accepts(st[g], cmd);
    assign hit[g]    = covers[g] && !bad && (cmd != C_NOP);
  end

  assign bad = |fail;

  always_comb begin
    bad_bank = '0;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (fail[b]) bad_bank = BA_W'(b);
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_guard_pkg::*;
#(
  parameter int TMR_W   = 4,
  parameter int TWR_CYC = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  cmd_e             cmd,
  input  logic             a10,
  input  logic [TMR_W-1:0] trp,
  input  logic [TMR_W-1:0] trcd,
  input  logic [TMR_W-1:0] burst,
  output bank_e            state
);
  localparam logic [TMR_W-1:0] ONE    = TMR_W'(1);
  localparam logic [TMR_W-1:0] TWR_LD = (TWR_CYC < 1) ? ONE : TMR_W'(TWR_CYC);

  logic [TMR_W-1:0] cnt;
  logic [TMR_W-1:0] trp_ld, trcd_ld;
  logic             last;

  assign trp_ld  = (trp  == '0) ? ONE : trp;
  assign trcd_ld = (trcd == '0) ? ONE : trcd;
  assign last    = (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= B_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        B_IDLE: if (hit && cmd == C_ACT) begin
          state <= B_OPENING;
          cnt   <= trcd_ld;
        end
        B_OPENING: if (last) state <= B_OPEN; else cnt <= cnt - ONE;
        B_OPEN: if (hit) begin
          if (cmd == C_RD && a10) begin
            state <= B_RD_AP;
            cnt   <= burst;
          end else if (cmd == C_WR && a10) begin
            state <= B_WR_AP;
            cnt   <= burst;
          end else if (cmd == C_PRE) begin
            state <= B_CLOSING;
            cnt   <= trp_ld;
          end
        end
        B_RD_AP: if (last) begin
          state <= B_CLOSING;
          cnt   <= trp_ld;
        end else cnt <= cnt - ONE;
        B_WR_AP: if (last) begin
          state <= B_WR_REC;
          cnt   <= TWR_LD;
        end else cnt <= cnt - ONE;
        B_WR_REC: if (last) begin
          state <= B_CLOSING;
          cnt   <= trp_ld;
        end else cnt <= cnt - ONE;
        B_CLOSING: if (last) state <= B_IDLE; else cnt <= cnt - ONE;
        default: state <= B_IDLE;
      endcase
    end
  end

  assert_timer_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != B_IDLE && state != B_OPEN) |-> cnt != '0);
  assert_idle_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state == B_IDLE |=> (state == B_IDLE || state == B_OPENING));
  assert_close_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == B_CLOSING && cnt == ONE) |=> state == B_IDLE);
  assert_rd_burst_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state == B_RD_AP |=> (state == B_RD_AP || state == B_CLOSING));
  assert_wr_burst_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state == B_WR_AP |=> (state == B_WR_AP || state == B_WR_REC));
endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdram_guard_pkg::*;
#(
  parameter int NBANK   = 4,
  parameter int TMR_W   = 4,
  parameter int TWR_CYC = 2,
  localparam int BA_W   = $clog2(NBANK)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               ras_n,
  input  logic               cas_n,
  input  logic               we_n,
  input  logic [BA_W-1:0]    ba,
  input  logic               a10,
  input  logic [TMR_W-1:0]   trp_cfg,
  input  logic [TMR_W-1:0]   trcd_cfg,
  input  logic [1:0]         bl_sel,
  output logic [3*NBANK-1:0] bank_state,
  output logic               illegal,
  output logic [BA_W-1:0]    illegal_bank,
  output logic [2:0]         illegal_code
);
  cmd_e             cmd;
  bank_e            st [NBANK];
  logic             bad;
  logic [BA_W-1:0]  bad_bank;
  logic [NBANK-1:0] hit;
  logic [TMR_W-1:0] burst;
  logic             all_idle;

  assign burst = TMR_W'(1) << bl_sel;

  sdram_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  sdram_cmd_judge #(.NBANK(NBANK)) u_judge (
    .cmd(cmd), .ba(ba), .a10(a10), .st(st),
    .bad(bad), .bad_bank(bad_bank), .hit(hit)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    sdram_bank_track #(.TMR_W(TMR_W), .TWR_CYC(TWR_CYC)) u_trk (
      .clk(clk), .rst_n(rst_n), .hit(hit[g]), .cmd(cmd), .a10(a10),
      .trp(trp_cfg), .trcd(trcd_cfg), .burst(burst), .state(st[g])
    );
    assign bank_state[3*g +: 3] = st[g];
  end

  always_comb begin
    all_idle = 1'b1;
    for (int b = 0; b < NBANK; b++) if (st[b] != B_IDLE) all_idle = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      illegal      <= 1'b0;
      illegal_bank <= '0;
      illegal_code <= '0;
    end else begin
      illegal      <= bad;
      illegal_bank <= bad ? bad_bank : '0;
      illegal_code <= bad ? cmd : 3'd0;
    end
  end

  assert_pulse_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(cmd) != C_NOP);
  assert_global_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == C_REF || cmd == C_MRS) && !bad) |-> all_idle);
  assert_nop_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == C_NOP |-> !bad);
endmodule

// File: tb/sim_sdram_cmd_guard.sv
module sim_sdram_cmd_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic a10 = 1'b0;
  logic [3:0] trp_cfg = 4'd2, trcd_cfg = 4'd3;
  logic [1:0] bl_sel = 2'd2;
  logic [11:0] bank_state;
  logic illegal;
  logic [1:0] illegal_bank;
  logic [2:0] illegal_code;

  int total = 0, bad = 0;
  int mst [4];
  int mcnt [4];
  localparam int TWR = 2;

  always #2.5 clk = ~clk;

  sdram_cmd_guard u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a10(a10), .trp_cfg(trp_cfg), .trcd_cfg(trcd_cfg), .bl_sel(bl_sel),
    .bank_state(bank_state), .illegal(illegal), .illegal_bank(illegal_bank),
    .illegal_code(illegal_code)
  );

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int ldv(int x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic bit takes(int st, int c);
    case (c)
      0: return 1'b1;
      1: return st != 4;
      2, 3: return st == 2;
      4: return st == 0;
      5: return st == 0 || st == 2 || st == 6;
      default: return st == 0;
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One command cycle: drive at negedge, model, compare after the edge.
  task automatic step(int c, bit desel, int b, bit a, string tag);
    bit ebad, all;
    int ebank;
    logic [3:0] pins;
    case (c)
      0: pins = 4'b0111; 1: pins = 4'b0110; 2: pins = 4'b0101; 3: pins = 4'b0100;
      4: pins = 4'b0011; 5: pins = 4'b0010; 6: pins = 4'b0001; default: pins = 4'b0000;
    endcase
    if (desel) begin
      pins = {1'b1, 3'($urandom)};
      c = 0;
    end
    {cs_n, ras_n, cas_n, we_n} = pins;
    ba = 2'(b);
    a10 = a;
    all = (c == 5 && a) || c >= 6;
    ebad = 0;
    ebank = 0;
    for (int k = 3; k >= 0; k--)
      if ((all || k == b) && !takes(mst[k], c)) begin ebad = 1; ebank = k; end
    @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      bit cov = (all || k == b) && !ebad;
      case (mst[k])
        0: if (cov && c == 4) begin mst[k] = 1; mcnt[k] = ldv(trcd_cfg); end
        1: if (mcnt[k] == 1) mst[k] = 2; else mcnt[k]--;
        2: if (cov) begin
             if (c == 2 && a) begin mst[k] = 3; mcnt[k] = 1 << bl_sel; end
             else if (c == 3 && a) begin mst[k] = 4; mcnt[k] = 1 << bl_sel; end
             else if (c == 5) begin mst[k] = 6; mcnt[k] = ldv(trp_cfg); end
           end
        3: if (mcnt[k] == 1) begin mst[k] = 6; mcnt[k] = ldv(trp_cfg); end else mcnt[k]--;
        4: if (mcnt[k] == 1) begin mst[k] = 5; mcnt[k] = TWR; end else mcnt[k]--;
        5: if (mcnt[k] == 1) begin mst[k] = 6; mcnt[k] = ldv(trp_cfg); end else mcnt[k]--;
        default: if (mcnt[k] == 1) mst[k] = 0; else mcnt[k]--;
      endcase
    end
    @(negedge clk);
    check(illegal == ebad, tag, "illegal", illegal, ebad);
    if (ebad) begin
      check(illegal_bank == 2'(ebank), tag, "illegal_bank", illegal_bank, ebank);
      check(illegal_code == 3'(c), tag, "illegal_code", illegal_code, c);
    end
    for (int k = 0; k < 4; k++)
      check(bank_state[3*k +: 3] == 3'(mst[k]), tag, $sformatf("bank%0d state", k),
            bank_state[3*k +: 3], mst[k]);
  endtask

  task automatic idle_wait(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, tag);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 4; k++) begin mst[k] = 0; mcnt[k] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(bank_state == 12'd0, "R1", "bank_state", bank_state, 0);
    check(illegal == 1'b0, "R1", "illegal", illegal, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, "R1");
    // R2: deselect with noise on the other pins
    for (int i = 0; i < 4; i++) step(7, 1, i, 1, "R2");
    // R6: read to idle bank
    step(2, 0, 1, 0, "R6");
    // R3: activate, observe opening window
    step(4, 0, 0, 0, "R3");
    idle_wait(3, "R3");
    // R4: commands to an opening bank
    step(4, 0, 2, 0, "R4");
    step(2, 0, 2, 0, "R4");
    step(5, 0, 2, 0, "R4");
    step(1, 0, 2, 0, "R4");
    step(4, 0, 2, 0, "R4");
    idle_wait(2, "R3");
    // R6: activate to open bank
    step(4, 0, 0, 0, "R6");
    // R8: plain write keeps bank open
    step(3, 0, 0, 0, "R8");
    // R10: refresh with banks busy
    step(6, 0, 3, 0, "R10");
    step(7, 0, 3, 0, "R10");
    // R7: read with auto-precharge, same bank blocked, other bank free
    step(2, 0, 0, 1, "R7");
    step(2, 0, 0, 0, "R7");
    step(4, 0, 1, 0, "R7");
    step(3, 0, 2, 0, "R7");
    // R9: precharge-all with busy banks
    step(5, 0, 3, 1, "R9");
    idle_wait(6, "R7");
    // R8: write with auto-precharge and a burst stop into it
    step(3, 0, 2, 1, "R8");
    step(1, 0, 2, 0, "R8");
    step(5, 0, 2, 0, "R8");
    idle_wait(8, "R8");
    // R5: single precharge and its window
    step(5, 0, 1, 0, "R5");
    step(5, 0, 1, 0, "R5");
    idle_wait(3, "R5");
    // R9: precharge-all on open banks
    step(4, 0, 3, 0, "R9");
    idle_wait(4, "R9");
    step(5, 0, 0, 1, "R9");
    idle_wait(3, "R9");
    // R10: refresh and mode set with all idle
    step(6, 0, 0, 0, "R10");
    step(7, 0, 0, 0, "R10");
    // R12: shortest burst and zero delays
    bl_sel = 2'd0; trcd_cfg = 4'd0; trp_cfg = 4'd0;
    step(4, 0, 1, 0, "R12");
    step(2, 0, 1, 1, "R12");
    idle_wait(3, "R12");
    bl_sel = 2'd3;
    step(4, 0, 1, 0, "R12");
    step(3, 0, 1, 1, "R12");
    idle_wait(13, "R12");
    // R11: random mix against the model
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom % 16);
      int c;
      if (i % 250 == 0) begin
        trp_cfg = 4'($urandom % 6); trcd_cfg = 4'($urandom % 6); bl_sel = 2'($urandom);
      end
      if (r < 2) c = 0; else if (r < 3) c = 1; else if (r < 6) c = 2;
      else if (r < 8) c = 3; else if (r < 11) c = 4; else if (r < 14) c = 5;
      else if (r < 15) c = 6; else c = 7;
      step(c, ($urandom % 8) == 0, int'($urandom % 4), 1'($urandom), "R11");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule